// File: doc/BRIEF.md
# Sampling Converter Control Interface

This block is the digital half of a 16-bit successive-approximation converter that has a parallel output bus. A host drives three control lines: an active-low chip select, a read/convert line and a byte-select line. The block answers with an active-low busy flag and a 16-bit bus. The bus is modelled as a data vector plus an output-enable flag. While the enable is low, the data vector reads as zero. The analog comparator is replaced by a digital two's-complement sample input. At the moment a start is recognised, the block captures that sample and then resolves it one bit per step, most significant bit first.

All three control lines first pass through a two-flop synchronizer. A controller state machine tracks each conversion through four states. IDLE moves to LAG when a start event is seen. LAG moves to SAR once the busy-lag count has elapsed. SAR moves to HOLD when the final bit is decided, and the result register is written on that same edge. HOLD moves back to IDLE once the data-lead count has elapsed. Busy is low in SAR and HOLD. The previous result therefore stays readable on the bus for the whole of SAR, and the new result sits on the bus for the data-lead cycles before busy rises. Lag, cycles per bit and lead are parameters counted in clock cycles.

Top module: `sarc_top`

## Requirements
- R1: After reset, busy_n is 1, bus_oe is 0, bus_data is 0, and the result register holds 0, so a read before any conversion returns 0x0000.
- R2: A start is a falling read/convert while chip select is low, or a falling chip select while read/convert is low. Counting the first rising clock edge after the pin change as edge 1, busy_n reads 0 after edge 3+BUSY_LAG.
- R3: bus_oe is 1 exactly when the synchronized chip select is low and the synchronized read/convert is high. Whenever bus_oe is 0, bus_data is 0. Either line changing takes effect on the bus after the second rising edge.
- R4: busy_n returns to 1 after edge 3+BUSY_LAG+16*BIT_CYCLES+DATA_LEAD, counted as in R2. The new result appears on the bus DATA_LEAD cycles earlier, after edge 3+BUSY_LAG+16*BIT_CYCLES.
- R5: A start event that arrives while busy_n is 0 does not restart the conversion. Neither the busy timing nor the result changes, and reads during the conversion remain possible.
- R6: With byte_sel at 0, result bit 15 appears on bus_data[15] with no reordering. With byte_sel at 1, bus_data[15:8] carries result[7:0] and bus_data[7:0] carries result[15:8].
- R7: The result of a conversion equals, bit for bit, the two's-complement sample present when the start was recognised. It is resolved one bit per BIT_CYCLES cycles, MSB first.
- R8: During SAR the bus, when enabled, still shows the previous conversion's result.
- R9: Changes on the sample input after the start has been recognised have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rc | input | 1 | Read (high) / convert (low) line |
| byte_sel | input | 1 | Swap upper and lower byte lanes when 1 |
| sample | input | 16 | Two's-complement value standing in for the analog input |
| busy_n | output | 1 | Low while a conversion is in progress |
| bus_data | output | 16 | Output data, zero while disabled |
| bus_oe | output | 1 | Output enable (0 models high impedance) |

## Verification
A wrong state or counter in the controller shows up as a busy edge landing one or more cycles off the computed edge count, and this is visible within the same conversion. A fault in the approximation register shows as a wrong code on the first read after busy rises. A result written too early shows as a changed bus value during SAR, one cycle after the bad write. Lane or gating faults show on the very next enabled read, two edges after the controlling line moves.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAG  = 2'd1,
        ST_SAR  = 2'd2,
        ST_HOLD = 2'd3
    } sarc_state_t;

    localparam int SARC_LANE_W = 8;
endpackage

// File: rtl/sarc_sync.sv
module sarc_sync #(
    parameter int             N       = 3,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= din[i];
                stab_q <= meta_q;
            end
        end
        assign lvl[i] = stab_q;
    end
endmodule

// File: rtl/sarc_ctrl.sv
module sarc_ctrl
    import sarc_pkg::*;
#(
    parameter int BUSY_LAG   = 2,
    parameter int BIT_CYCLES = 2,
    parameter int DATA_LEAD  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_lvl_n,
    input  logic        rc_lvl,
    input  logic        last_bit,
    output logic        load,
    output logic        step,
    output logic        busy_n,
    output sarc_state_t state
);
    localparam int CNT_MAX = (BUSY_LAG > BIT_CYCLES) ?
                             ((BUSY_LAG > DATA_LEAD) ? BUSY_LAG : DATA_LEAD) :
                             ((BIT_CYCLES > DATA_LEAD) ? BIT_CYCLES : DATA_LEAD);
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] LAG_END  = CW'(BUSY_LAG - 1);
    localparam logic [CW-1:0] BIT_END  = CW'(BIT_CYCLES - 1);
    localparam logic [CW-1:0] LEAD_END = CW'(DATA_LEAD - 1);

    sarc_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          cs_prev_q, rc_prev_q;
    logic          start;

    // Edge detection on synchronized levels; either line may complete the start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev_q <= 1'b1;
            rc_prev_q <= 1'b1;
        end else begin
            cs_prev_q <= cs_lvl_n;
            rc_prev_q <= rc_lvl;
        end
    end

    assign start = (rc_prev_q & ~rc_lvl & ~cs_lvl_n) |
                   (cs_prev_q & ~cs_lvl_n & ~rc_lvl);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_LAG;
                    cnt_d   = '0;
                end
            end
            ST_LAG: begin
                if (cnt_q == LAG_END) begin
                    state_d = ST_SAR;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SAR: begin
                if (cnt_q == BIT_END) begin
                    cnt_d = '0;
                    if (last_bit) state_d = ST_HOLD;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q == LEAD_END) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        busy_n = 1'b1;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_LAG:  busy_n = 1'b1;
            ST_SAR: begin
                busy_n = 1'b0;
                step   = (cnt_q == BIT_END);
            end
            ST_HOLD: busy_n = 1'b0;
            default: busy_n = 1'b1;
        endcase
    end

    assign state = state_q;

    // R5: a conversion is only ever entered from IDLE, so a start during busy cannot restart it
    p_lag_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAG && $past(state_q) != ST_LAG) |-> $past(state_q) == ST_IDLE);

    // R5: a start seen outside IDLE leaves the state sequence alone
    p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAR && start) |=> (state_q == ST_SAR || state_q == ST_HOLD));
endmodule

// File: rtl/sarc_sar.sv
module sarc_sar #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] sample,
    output logic         last_bit,
    output logic         res_wr,
    output logic [W-1:0] result
);
    logic [W-1:0] target_q, acc_q, mask_q, result_q;
    logic [W-1:0] cand, acc_n;

    assign cand     = acc_q | mask_q;
    assign acc_n    = (cand <= target_q) ? cand : acc_q;
    assign last_bit = mask_q[0];
    assign res_wr   = step & mask_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
            acc_q    <= '0;
            mask_q   <= '0;
            result_q <= '0;
        end else if (load) begin
            // offset-binary target makes the unsigned trial comparison monotonic
            target_q <= {~sample[W-1], sample[W-2:0]};
            acc_q    <= '0;
            mask_q   <= {1'b1, {(W-1){1'b0}}};
        end else if (step) begin
            acc_q  <= acc_n;
            mask_q <= mask_q >> 1;
            if (mask_q[0]) result_q <= {~acc_n[W-1], acc_n[W-2:0]};
        end
    end

    assign result = result_q;

    // R7: exactly one trial bit is live at a time
    p_mask_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mask_q));

    // R7: the written code matches the captured target after the final bit
    p_exact_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |=> result_q == {~$past(target_q[W-1]), $past(target_q[W-2:0])});
endmodule

// File: rtl/sarc_bus.sv
module sarc_bus
    import sarc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] result,
    input  logic         cs_lvl_n,
    input  logic         rc_lvl,
    input  logic         byte_lvl,
    output logic [W-1:0] data,
    output logic         oe
);
    localparam int LW = SARC_LANE_W;
    localparam int NL = W / LW;

    assign oe = ~cs_lvl_n & rc_lvl;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [LW-1:0] straight, swapped;
        assign straight = result[l*LW +: LW];
        assign swapped  = result[(NL-1-l)*LW +: LW];
        assign data[l*LW +: LW] = oe ? (byte_lvl ? swapped : straight) : '0;
    end
endmodule

// File: rtl/sarc_top.sv
module sarc_top
    import sarc_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int BUSY_LAG   = 2,
    parameter int BIT_CYCLES = 2,
    parameter int DATA_LEAD  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rc,
    input  logic              byte_sel,
    input  logic [DATA_W-1:0] sample,
    output logic              busy_n,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe
);
    logic [2:0]        lvl;
    logic              load, step, last_bit, res_wr;
    logic [DATA_W-1:0] result;
    sarc_state_t       state;

    sarc_sync #(.N(3), .RST_VAL(3'b011)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({byte_sel, rc, cs_n}),
        .lvl   (lvl)
    );

    sarc_ctrl #(
        .BUSY_LAG   (BUSY_LAG),
        .BIT_CYCLES (BIT_CYCLES),
        .DATA_LEAD  (DATA_LEAD)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_lvl_n (lvl[0]),
        .rc_lvl   (lvl[1]),
        .last_bit (last_bit),
        .load     (load),
        .step     (step),
        .busy_n   (busy_n),
        .state    (state)
    );

    sarc_sar #(.W(DATA_W)) i_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .sample   (sample),
        .last_bit (last_bit),
        .res_wr   (res_wr),
        .result   (result)
    );

    sarc_bus #(.W(DATA_W)) i_bus (
        .result   (result),
        .cs_lvl_n (lvl[0]),
        .rc_lvl   (lvl[1]),
        .byte_lvl (lvl[2]),
        .data     (bus_data),
        .oe       (bus_oe)
    );

    // R3: a deselected chip never drives the bus
    p_hiz_cs_r3: assert property (@(posedge clk) disable iff (!rst_n) lvl[0] |-> !bus_oe);

    // R4: the result is written while busy is low and busy stays low the cycle after
    p_write_busy_r4: assert property (@(posedge clk) disable iff (!rst_n) res_wr |-> !busy_n);
    p_lead_busy_r4: assert property (@(posedge clk) disable iff (!rst_n) res_wr |=> !busy_n);

    // R8: the output register only moves during the held part of a conversion
    p_result_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && state == ST_IDLE) |=> $stable(result));
endmodule

// File: tb/test_sarc_top.sv
module test_sarc_top;
    localparam int W       = 16;
    localparam int LAG     = 2;
    localparam int BITC    = 2;
    localparam int LEAD    = 3;
    localparam int T_FALL  = 3 + LAG;
    localparam int T_LATCH = 3 + LAG + W * BITC;
    localparam int T_RISE  = T_LATCH + LEAD;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n, cs_n, rc, byte_sel, busy_n, bus_oe;
    logic [W-1:0] sample, bus_data;
    int           total = 0, bad = 0;
    logic [W-1:0] prev_res;

    sarc_top #(.DATA_W(W), .BUSY_LAG(LAG), .BIT_CYCLES(BITC), .DATA_LEAD(LEAD)) i_sarc_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc(rc), .byte_sel(byte_sel),
        .sample(sample), .busy_n(busy_n), .bus_data(bus_data), .bus_oe(bus_oe)
    );

    function automatic logic [W-1:0] lanes(input logic [W-1:0] v, input logic b);
        return b ? {v[7:0], v[15:8]} : v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic conv(input int mode, input logic [W-1:0] smp, input bit bsel,
                        input bit restart, input logic [W-1:0] other);
        int fall_n = -1;
        int rise_n = -1;
        @(negedge clk);
        byte_sel = bsel;
        if (mode == 0) begin cs_n = 1'b0; rc = 1'b1; end
        else           begin cs_n = 1'b1; rc = 1'b0; end
        repeat (4) @(negedge clk);
        sample = smp;
        if (mode == 0) rc = 1'b0; else cs_n = 1'b0;
        for (int n = 1; n <= T_RISE + 2; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (!busy_n && fall_n < 0) fall_n = n;
            if (busy_n && fall_n >= 0 && rise_n < 0) rise_n = n;
            if (mode == 0) begin
                if (n >= 4 && !(restart && n >= 11 && n <= 14)) begin
                    // R8 previous result during conversion, R4 new result from the write edge, R6 lanes
                    chk(bus_oe === 1'b1, "R3 read enabled", {31'b0, bus_oe}, 32'd1);
                    chk(bus_data === lanes((n < T_LATCH) ? prev_res : smp, bsel),
                        (n < T_LATCH) ? "R8 previous result" : "R4 new result", bus_data,
                        lanes((n < T_LATCH) ? prev_res : smp, bsel));
                end
                if (n == 1) rc = 1'b1;
                if (restart && n == 10) begin rc = 1'b0; sample = other; end
                if (restart && n == 11) rc = 1'b1;
            end else begin
                chk(bus_oe === 1'b0 && bus_data === '0, "R3 bus off while rc low",
                    {15'b0, bus_oe, bus_data}, 32'd0);
            end
            if (n == T_LATCH - 3) sample = ~smp;   // R9: late sample change
        end
        chk(fall_n == T_FALL, "R2 busy fall edge", fall_n, T_FALL);
        chk(rise_n == T_RISE, restart ? "R5 busy rise after ignored start" : "R4 busy rise edge",
            rise_n, T_RISE);
        if (mode == 1) begin
            rc = 1'b1;
            repeat (3) @(negedge clk);
        end
        chk(bus_oe === 1'b1 && bus_data === lanes(smp, bsel),
            restart ? "R5 result kept" : "R7 result code", bus_data, lanes(smp, bsel));
        prev_res = smp;
        cs_n = 1'b1;
        rc   = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_oe === 1'b0 && bus_data === '0, "R3 bus off when deselected",
            {15'b0, bus_oe, bus_data}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; rc = 1'b1; byte_sel = 1'b0; sample = '0;
        repeat (3) @(negedge clk);
        chk(busy_n === 1'b1, "R1 busy after reset", {31'b0, busy_n}, 32'd1);
        chk(bus_oe === 1'b0 && bus_data === '0, "R1 bus after reset", {15'b0, bus_oe, bus_data}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(bus_oe === 1'b1 && bus_data === '0, "R1 reset result", bus_data, 32'd0);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        prev_res = '0;

        conv(0, 16'h8000, 1'b0, 1'b0, '0);
        conv(1, 16'h7FFF, 1'b1, 1'b0, '0);
        conv(0, 16'h0000, 1'b1, 1'b1, 16'h1234);
        conv(1, 16'hFFFF, 1'b0, 1'b0, '0);
        conv(0, 16'h0001, 1'b0, 1'b0, '0);
        conv(0, 16'h00FF, 1'b1, 1'b0, '0);
        for (int k = 0; k < 64; k++) begin
            logic [W-1:0] v;
            v = 16'(k * 1031) ^ 16'(k << 9);
            conv(k % 2, v, (k / 2) % 2 == 1, (k % 4) == 0, ~v);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule